// File: doc/BRIEF.md
# PCI Configuration Address/Data Port Bridge

This block turns host accesses into configuration-space requests. Software first writes a 32-bit configuration address into a byte-addressable address port. It then reads or writes through a four-byte data window. The address selects bus, device, function and dword register. The byte offset of the data-window access supplies the two low address bits. An optional flat window gives a second way in: its host offset is used directly as the configuration address, and no address port is needed.

Each access arrives on a valid/ready host port that carries a space selector, an offset, a byte length (1 to 4) and right-aligned write data. Read data returns right-aligned in the cycle in which ready is high. Requests to a present function go out as one lane-aligned, byte-enabled request to a configuration register file, and the host waits until the register file accepts it. Accesses to an absent function, misaligned flat accesses and accesses to the unused space complete at once and never reach the register file.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the latched configuration address reads as 0.
- R2: An address-port write at byte offset k with length L updates only lanes k up to min(k+L,4)-1 of the latched address. Host byte i goes to lane k+i, and bits 1:0 always stay 0. The register changes only on such a write.
- R3: An address-port read at offset k returns the latched address shifted down by k bytes, with bytes beyond the clipped length reading as 0.
- R4: The latched address splits into these fields: bus in bits 23:16, device in 15:11, function in 10:8 and dword index in 7:2. A data-window access at offset k sends cfg_dev equal to the device field and cfg_off equal to dword*4+k.
- R5: The length of a data-window or flat access is clipped to min(L,4-k). cfg_be sets exactly lanes k up to k+len-1 (bit n is lane n, lane n = bits 8n+7:8n), and cfg_wdata carries host byte i in lane k+i with all other lanes 0.
- R6: A function is present only when its bus equals HOST_BUS, its function field is 0 and DEV_MASK has the bit for its device set. The enable bit takes no part in this decision. For an absent target a read returns 0xFF in every requested byte and 0 above them, a write produces no request, and both complete in the cycle they are presented.
- R7: A present read returns cfg_rdata shifted down by k bytes and masked to the clipped length.
- R8: Space 2 is the flat window. Its offset bits 23:16, 15:11, 10:8, 7:2 and 1:0 are used as bus, device, function, dword and byte offset, with the same presence rule.
- R9: A flat access with (offset mod 4) + length > 4 produces no request, completes at once and reads as 0.
- R10: Space 3 is unused. It completes at once, reads as 0 and has no effect.
- R11: A request to a present function holds cfg_valid, and req_ready stays low, until cfg_ready is high. The access then finishes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access valid |
| req_ready | output | 1 | Host access completes this cycle |
| req_space | input | 2 | 0 address port, 1 data window, 2 flat window, 3 unused |
| req_addr | input | FLAT_AW | Byte offset in the selected space |
| req_len | input | 3 | Access length in bytes (1 to 4) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Right-aligned write data |
| req_rdata | output | 32 | Right-aligned read data, valid with req_ready |
| cfg_valid | output | 1 | Request to the register file |
| cfg_ready | input | 1 | Register file accepts the request |
| cfg_write | output | 1 | Request is a write |
| cfg_dev | output | 5 | Device number |
| cfg_off | output | 8 | Byte offset in the function's configuration space |
| cfg_be | output | 4 | Lane byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Lane-aligned read data |

## Verification
On every cycle the assertions check several properties. The latched address holds unless an address-port write occurs. Forwarded byte enables start at the offset lane and stay inside the dword. No request is forwarded for a device outside the implemented mask. Rejected flat accesses and the unused space complete at once, and a pending request stays steady until it is accepted. The bench scenarios show the data values: lane placement and clipping on the address port, the all-ones pattern for absent targets, field extraction from both windows, and the exact number of wait cycles when the register file stalls.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
   typedef enum logic [1:0] {
      SP_ADDR = 2'd0,
      SP_DATA = 2'd1,
      SP_FLAT = 2'd2,
      SP_NONE = 2'd3
   } space_e;

   localparam int LANES  = 4;
   localparam int DWW    = 8 * LANES;
   localparam int DEV_W  = 5;
   localparam int FN_W   = 3;
   localparam int BUS_W  = 8;
   localparam int DWORD_W = 6;

   // clipped byte-enable for an access of len bytes starting at lane k
   function automatic logic [LANES-1:0] lane_enables(input logic [1:0] k,
                                                     input logic [2:0] len);
      logic [2:0] room;
      logic [2:0] eff;
      logic [4:0] run;
      room = 3'd4 - {1'b0, k};
      eff  = (len > room) ? room : len;
      run  = (5'd1 << eff) - 5'd1;
      return run[3:0] << k;
   endfunction
endpackage

// File: rtl/cpb_lane_shaper.sv
module cpb_lane_shaper
   import cpb_pkg::*;
(
   input  logic [1:0]       k,
   input  logic [2:0]       len,
   input  logic [DWW-1:0]   wdata_r,
   input  logic [DWW-1:0]   rdata_l,
   output logic [LANES-1:0] be,
   output logic [DWW-1:0]   wdata_l,
   output logic [DWW-1:0]   rdata_r
);
   logic [DWW-1:0] bytemask;

   assign be = lane_enables(k, len);

   for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign bytemask[8*i +: 8] = {8{be[i]}};
   end

   assign wdata_l = (wdata_r << (8 * k)) & bytemask;
   assign rdata_r = (rdata_l & bytemask) >> (8 * k);
endmodule

// File: rtl/cpb_addr_latch.sv
module cpb_addr_latch
   import cpb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LANES-1:0] be,
   input  logic [DWW-1:0]   wdata_l,
   output logic [DWW-1:0]   addr_q
);
   logic [DWW-1:0] merged;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign merged[8*i +: 8] = be[i] ? wdata_l[8*i +: 8] : addr_q[8*i +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (wr_en)
         addr_q <= merged & ~DWW'(3);
   end

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(addr_q));
endmodule

// File: rtl/cpb_target_decode.sv
module cpb_target_decode
   import cpb_pkg::*;
#(
   parameter int          HOST_BUS = 0,
   parameter logic [31:0] DEV_MASK = 32'h0000_000B
)(
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   input  logic [FN_W-1:0]  fn,
   output logic             present
);
   assign present = (bus == BUS_W'(HOST_BUS)) && (fn == '0) && DEV_MASK[dev];
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
   import cpb_pkg::*;
#(
   parameter int          HOST_BUS = 0,
   parameter logic [31:0] DEV_MASK = 32'h0000_000B,
   parameter bit          FLAT_EN  = 1'b1,
   parameter int          FLAT_AW  = 24
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [1:0]         req_space,
   input  logic [FLAT_AW-1:0] req_addr,
   input  logic [2:0]         req_len,
   input  logic               req_write,
   input  logic [31:0]        req_wdata,
   output logic [31:0]        req_rdata,
   output logic               cfg_valid,
   input  logic               cfg_ready,
   output logic               cfg_write,
   output logic [4:0]         cfg_dev,
   output logic [7:0]         cfg_off,
   output logic [3:0]         cfg_be,
   output logic [31:0]        cfg_wdata,
   input  logic [31:0]        cfg_rdata
);
   if (FLAT_AW < 24 || FLAT_AW > 31) begin : g_bad_aw
      $error("FLAT_AW must lie between 24 and 31");
   end
   if (HOST_BUS < 0 || HOST_BUS > 255) begin : g_bad_bus
      $error("HOST_BUS must fit in eight bits");
   end

   logic [1:0]         k;
   logic               addr_sel, data_sel, flat_sel, reject, cfg_sel, present, cfg_go;
   logic [DWW-1:0]     addr_q, wlanes, rsrc, rshaped;
   logic [LANES-1:0]   be;
   logic [BUS_W-1:0]   bus_m;
   logic [DEV_W-1:0]   dev_m;
   logic [FN_W-1:0]    fn_m;
   logic [DWORD_W-1:0] dword_m;

   assign k        = req_addr[1:0];
   assign addr_sel = (req_space == SP_ADDR);
   assign data_sel = (req_space == SP_DATA);

   if (FLAT_EN) begin : g_flat
      assign flat_sel = (req_space == SP_FLAT);
   end else begin : g_noflat
      assign flat_sel = 1'b0;
   end

   assign reject  = flat_sel && (({2'b00, k} + {1'b0, req_len}) > 4'd4);
   assign cfg_sel = data_sel || (flat_sel && !reject);

   assign bus_m   = flat_sel ? req_addr[23:16] : addr_q[23:16];
   assign dev_m   = flat_sel ? req_addr[15:11] : addr_q[15:11];
   assign fn_m    = flat_sel ? req_addr[10:8]  : addr_q[10:8];
   assign dword_m = flat_sel ? req_addr[7:2]   : addr_q[7:2];

   cpb_target_decode #(.HOST_BUS(HOST_BUS), .DEV_MASK(DEV_MASK)) decode_i (
      .bus(bus_m), .dev(dev_m), .fn(fn_m), .present(present)
   );

   cpb_lane_shaper shaper_i (
      .k(k), .len(req_len), .wdata_r(req_wdata), .rdata_l(rsrc),
      .be(be), .wdata_l(wlanes), .rdata_r(rshaped)
   );

   cpb_addr_latch latch_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(req_valid && addr_sel && req_write),
      .be(be), .wdata_l(wlanes), .addr_q(addr_q)
   );

   assign cfg_go = cfg_sel && present && (be != '0);

   always_comb begin
      if (addr_sel)                rsrc = addr_q;
      else if (cfg_go)             rsrc = cfg_rdata;
      else if (cfg_sel && !present) rsrc = '1;
      else                         rsrc = '0;
   end

   assign req_ready = !cfg_go || cfg_ready;
   assign req_rdata = req_write ? '0 : rshaped;
   assign cfg_valid = req_valid && cfg_go;
   assign cfg_write = req_write;
   assign cfg_dev   = dev_m;
   assign cfg_off   = {dword_m, k};
   assign cfg_be    = be;
   assign cfg_wdata = wlanes;

   assert_fwd_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> DEV_MASK[cfg_dev]);

   assert_be_in_dword_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> (cfg_be[cfg_off[1:0]] &&
                     ((cfg_be & ((4'b0001 << cfg_off[1:0]) - 4'b0001)) == 4'b0000)));

   assert_flat_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_space == SP_FLAT && FLAT_EN &&
       ({2'b00, req_addr[1:0]} + {1'b0, req_len}) > 4'd4) |-> (!cfg_valid && req_ready));

   assert_unused_space_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_space == SP_NONE) |-> (req_ready && !cfg_valid && req_rdata == '0));

   assert_hold_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_off) && $stable(cfg_be)));
endmodule

// File: tb/cfg_port_bridge_tb_top.sv
module cfg_port_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_space = 2'd0;
   logic [23:0] req_addr = '0;
   logic [2:0]  req_len = 3'd4;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [31:0] req_rdata;
   logic        cfg_valid, cfg_ready, cfg_write;
   logic [4:0]  cfg_dev;
   logic [7:0]  cfg_off;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata, cfg_rdata;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   cfg_port_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_space(req_space), .req_addr(req_addr), .req_len(req_len),
      .req_write(req_write), .req_wdata(req_wdata), .req_rdata(req_rdata),
      .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
      .cfg_dev(cfg_dev), .cfg_off(cfg_off), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   // register-file model: lane0 96, lane1 C3, lane2 dword*4, lane3 dev^30
   logic [3:0]  lat = 4'd0;
   logic [3:0]  wcnt;
   int          nreq;
   logic [4:0]  cap_dev;
   logic [7:0]  cap_off;
   logic [3:0]  cap_be;
   logic [31:0] cap_wdata;

   assign cfg_rdata = {({3'b000, cfg_dev} ^ 8'h30), {cfg_off[7:2], 2'b00}, 8'hC3, 8'h96};
   assign cfg_ready = cfg_valid && (wcnt >= lat);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt <= '0;
         nreq <= 0;
      end else begin
         wcnt <= (cfg_valid && !cfg_ready) ? wcnt + 4'd1 : 4'd0;
         if (cfg_valid && cfg_ready) begin
            nreq <= nreq + 1;
            if (cfg_write) begin
               cap_dev   <= cfg_dev;
               cap_off   <= cfg_off;
               cap_be    <= cfg_be;
               cap_wdata <= cfg_wdata;
            end
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic host(input logic [1:0] sp, input logic [23:0] a, input logic [2:0] len,
                       input logic wr, input logic [31:0] wd,
                       output logic [31:0] rd, output int waits);
      @(negedge clk);
      req_valid = 1'b1; req_space = sp; req_addr = a; req_len = len;
      req_write = wr; req_wdata = wd;
      waits = 0;
      #1;
      while (!req_ready) begin
         waits++;
         @(negedge clk);
         #1;
      end
      rd = req_rdata;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   // {address value, data-window offset, length, expected read}
   localparam logic [68:0] TBL [8] = '{
      {32'h8000_0804, 2'd0, 3'd4, 32'h3104_C396},
      {32'h8000_0804, 2'd1, 3'd4, 32'h0031_04C3},
      {32'h8000_1810, 2'd2, 3'd2, 32'h0000_3310},
      {32'h8000_1000, 2'd0, 3'd4, 32'hFFFF_FFFF},
      {32'h8001_0800, 2'd3, 3'd2, 32'h0000_00FF},
      {32'h8000_0900, 2'd0, 3'd1, 32'h0000_00FF},
      {32'h0000_0808, 2'd3, 3'd1, 32'h0000_0031},
      {32'h8000_0000, 2'd1, 3'd2, 32'h0000_00C3}
   };

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int w, n0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset value
      host(2'd0, 24'h0, 3'd4, 1'b0, 0, rd, w);
      check("R1 reset address", rd, 32'h0);

      // R2/R3 address port lanes
      host(2'd0, 24'h0, 3'd4, 1'b1, 32'h8000_0804, rd, w);
      host(2'd0, 24'h0, 3'd4, 1'b0, 0, rd, w);
      check("R2 full write", rd, 32'h8000_0804);
      host(2'd0, 24'h2, 3'd1, 1'b1, 32'h0000_0055, rd, w);
      host(2'd0, 24'h0, 3'd4, 1'b0, 0, rd, w);
      check("R2 lane2 write", rd, 32'h8055_0804);
      host(2'd0, 24'h0, 3'd1, 1'b1, 32'h0000_00FF, rd, w);
      host(2'd0, 24'h0, 3'd4, 1'b0, 0, rd, w);
      check("R2 low bits zero", rd, 32'h8055_08FC);
      host(2'd0, 24'h3, 3'd2, 1'b0, 0, rd, w);
      check("R3 clipped read", rd, 32'h0000_0080);
      host(2'd0, 24'h3, 3'd4, 1'b1, 32'h1122_3344, rd, w);
      host(2'd0, 24'h0, 3'd4, 1'b0, 0, rd, w);
      check("R2 clipped write", rd, 32'h4455_08FC);

      // R4 R5 R6 R7 table walk over data window
      foreach (TBL[i]) begin
         host(2'd0, 24'h0, 3'd4, 1'b1, TBL[i][68:37], rd, w);
         host(2'd1, {22'h0, TBL[i][36:35]}, TBL[i][34:32], 1'b0, 0, rd, w);
         check($sformatf("R7 R6 R5 table entry %0d", i), rd, TBL[i][31:0]);
      end

      // R4 R5 data-window write placement
      host(2'd0, 24'h0, 3'd4, 1'b1, 32'h8000_0808, rd, w);
      n0 = nreq;
      host(2'd1, 24'h1, 3'd4, 1'b1, 32'hAABB_CCDD, rd, w);
      check("R5 write data lanes", cap_wdata, 32'hBBCC_DD00);
      check("R5 write enables", {28'h0, cap_be}, 32'hE);
      check("R4 write offset", {24'h0, cap_off}, 32'h9);
      check("R4 write device", {27'h0, cap_dev}, 32'h1);
      check("R4 write count", nreq, n0 + 1);

      // R6 absent write dropped
      host(2'd0, 24'h0, 3'd4, 1'b1, 32'h8000_1000, rd, w);
      n0 = nreq;
      host(2'd1, 24'h0, 3'd4, 1'b1, 32'h1234_5678, rd, w);
      check("R6 absent write no request", nreq, n0);
      check("R6 absent write no wait", w, 0);

      // R11 wait states
      host(2'd0, 24'h0, 3'd4, 1'b1, 32'h8000_0808, rd, w);
      lat = 4'd3;
      host(2'd1, 24'h0, 3'd4, 1'b0, 0, rd, w);
      check("R11 wait cycles", w, 3);
      check("R11 read after wait", rd, 32'h3108_C396);

      // R8 flat window
      lat = 4'd2;
      host(2'd2, 24'h00_0809, 3'd2, 1'b0, 0, rd, w);
      check("R8 flat read", rd, 32'h0000_08C3);
      check("R8 flat waits", w, 2);
      host(2'd2, 24'h01_0800, 3'd4, 1'b0, 0, rd, w);
      check("R8 flat absent bus", rd, 32'hFFFF_FFFF);
      n0 = nreq;
      host(2'd2, 24'h00_080C, 3'd4, 1'b1, 32'h0102_0304, rd, w);
      check("R8 flat write data", cap_wdata, 32'h0102_0304);
      check("R8 flat write offset", {24'h0, cap_off}, 32'h0C);
      check("R8 flat write enables", {28'h0, cap_be}, 32'hF);
      check("R8 flat write count", nreq, n0 + 1);

      // R9 misaligned flat
      n0 = nreq;
      host(2'd2, 24'h00_0802, 3'd4, 1'b0, 0, rd, w);
      check("R9 reject read data", rd, 32'h0);
      check("R9 reject no wait", w, 0);
      host(2'd2, 24'h00_0803, 3'd2, 1'b1, 32'hDEAD_BEEF, rd, w);
      check("R9 reject no request", nreq, n0);

      // R10 unused space
      host(2'd3, 24'h00_0800, 3'd4, 1'b1, 32'hFFFF_FFFF, rd, w);
      host(2'd3, 24'h00_0800, 3'd4, 1'b0, 0, rd, w);
      check("R10 unused read", rd, 32'h0);
      check("R10 unused no request", nreq, n0);
      host(2'd0, 24'h0, 3'd4, 1'b0, 0, rd, w);
      check("R10 address untouched", rd, 32'h8000_0808);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule